// File: doc/BRIEF.md
# Extension-Class Opcode Decoder

This block classifies 12-bit instruction words of the extension class, which is the class whose three top bits are all ones. It turns each such word into one-hot subclass selects and a set of decoded fields. An execution pipeline uses those outputs to steer the ALU, branch, stack, increment/decrement and page-zero call units. The block does not perform any of those operations.

The block also owns the small pieces of machine state that the control and page/channel opcodes write: a halt flag, an interrupt-enable flag, a trap-enable flag, a 5-bit page register and a 4-bit channel register. The halt flag is the visible face of a two-state machine. In state RUN the machine is running. The transition RUN to HALT is taken when a halt opcode is decoded. The HALT state has no exit except reset. Decoding continues in both states.

All decoded outputs are registered. A word presented with `insn_valid` high at a rising edge appears on the outputs for exactly the following cycle. Reset is asynchronous and active low.

Top module: `xcls_decoder`

## Requirements
- R1: `dec_valid` is high in the cycle after a rising edge at which `insn_valid` was high and `insn[11:9]` equalled 3'b111. Any other word produces `dec_valid`=0, all selects 0 and `illegal`=0.
- R2: For a legal extension word, exactly one `sub_sel` bit is high. The bit is chosen by `insn[8:6]`: bit0 control (000), bit1 page/channel set (001), bit2 ALU (010), bit3 branch (011), bit4 stack (100), bit5 increment/decrement (101), bit6 page-zero call (110 or 111).
- R3: Control subclass, low six bits: 000000 sets the halt flag. 000001 clears `irq_en`. 000010 clears `trap_en`. 001001 sets `irq_en`. 001010 sets `trap_en`. Every other control code is illegal.
- R4: Subclass 001 with `insn[5]`=0 loads `page_q` from `insn[4:0]`. With `insn[5:4]`=10 it loads `chan_q` from `insn[3:0]`. With `insn[5:4]`=11 the word is illegal.
- R5: The ALU subclass is always legal. It outputs `reg_field`={0,`insn[5:4]`} and `alu_fn`=`insn[3:0]`. `alu_fn` is 0 for every other word.
- R6: The branch subclass is legal when `insn[3]`=1 (conditional, `reg_field`=`insn[2:0]`) or when `insn[3:0]`=0000. Any other branch word is illegal.
- R7: The stack subclass is legal only when `insn[4:3]`=00. `is_pop` equals `insn[5]`, and `reg_field`=`insn[2:0]`.
- R8: The increment/decrement subclass is legal only when `insn[5:4]`=00. `step_up` equals `insn[3]`, and `reg_field`=`insn[2:0]`.
- R9: For the page-zero call, `zp_ptr`=`insn[6:0]`. It is 0 for every other word.
- R10: An illegal word raises `illegal` for one cycle. It clears every select and field output, and it leaves the halt, enable, page and channel state unchanged.
- R11: After reset, every output is 0.
- R12: Once `halted` is set, it stays set until reset.
- R13: In a cycle after an edge with no extension word, every select and field output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| insn_valid | input | 1 | Instruction word strobe |
| insn | input | 12 | Instruction word |
| dec_valid | output | 1 | Registered: an extension-class word was decoded |
| sub_sel | output | 7 | One-hot subclass select |
| reg_field | output | 3 | Register or condition field |
| alu_fn | output | 4 | ALU function field |
| step_up | output | 1 | Increment (1) or decrement (0) |
| is_pop | output | 1 | Stack pop (1) or push (0) |
| zp_ptr | output | 7 | Page-zero pointer address |
| illegal | output | 1 | Undefined or reserved encoding |
| halted | output | 1 | Halt flag (state HALT) |
| irq_en | output | 1 | Interrupt-enable flag |
| trap_en | output | 1 | Trap-enable flag |
| page_q | output | 5 | Page register |
| chan_q | output | 4 | Channel register |

## Verification
Directed words walk through every defined control code and several undefined neighbours, such as 000011 and 001000. They also cover the page and channel loads and the reserved 11 case of subclass 001. This shows the exact matching of control codes apart from approximate matching, and shows that rejected loads do not touch state. Branch words with a zero and a nonzero condition in the unconditional form, plus stack and increment/decrement words with stray middle bits, tell legal forms from reserved ones. Non-extension words and idle cycles separate class membership from strobe timing. A long random stream, biased toward the extension class, is then compared every cycle against a behavioural model. This covers combinations that directed cases miss, such as enable and disable toggles that follow a halt.

// File: rtl/xd_pkg.sv
package xd_pkg;
    localparam int INSN_W  = 12;
    localparam int NSEL    = 7;
    localparam int PAGE_W  = 5;
    localparam int CHAN_W  = 4;
    localparam int PTR_W   = 7;
    localparam int RF_W    = 3;
    localparam int FN_W    = 4;

    typedef enum logic [2:0] {
        SC_CTRL   = 3'b000,
        SC_PGCH   = 3'b001,
        SC_ALU    = 3'b010,
        SC_BRANCH = 3'b011,
        SC_STACK  = 3'b100,
        SC_INCDEC = 3'b101,
        SC_CALLZA = 3'b110,
        SC_CALLZB = 3'b111
    } subclass_e;

    typedef enum logic [2:0] {
        CA_NONE,
        CA_HALT,
        CA_IRQ_OFF,
        CA_TRAP_OFF,
        CA_IRQ_ON,
        CA_TRAP_ON
    } ctrl_act_e;

    typedef enum logic [1:0] {
        LD_NONE,
        LD_PAGE,
        LD_CHAN
    } load_e;

    typedef struct packed {
        logic                 valid;
        logic                 illegal;
        logic [NSEL-1:0]      sel;
        logic [RF_W-1:0]      rfield;
        logic [FN_W-1:0]      fn;
        logic                 up;
        logic                 pop;
        logic [PTR_W-1:0]     ptr;
        ctrl_act_e            act;
        load_e                ld;
        logic [PAGE_W-1:0]    page_val;
        logic [CHAN_W-1:0]    chan_val;
    } dec_s;
endpackage

// File: rtl/xd_classify.sv
module xd_classify
    import xd_pkg::*;
(
    input  logic              insn_valid,
    input  logic [INSN_W-1:0] insn,
    output dec_s              dec
);
    localparam int SC_LSB = INSN_W - 6;
    localparam int CL_LSB = INSN_W - 3;

    subclass_e        sc;
    logic             is_ext;
    logic [2:0]       sel_idx;
    logic [NSEL-1:0]  sel_hot;
    logic [5:0]       low6;

    assign is_ext  = insn_valid && (insn[INSN_W-1:CL_LSB] == 3'b111);
    assign sc      = subclass_e'(insn[SC_LSB+2:SC_LSB]);
    assign sel_idx = (sc == SC_CALLZB) ? 3'(SC_CALLZA) : insn[SC_LSB+2:SC_LSB];
    assign low6    = insn[5:0];

    for (genvar i = 0; i < NSEL; i++) begin : g_sel
        assign sel_hot[i] = (sel_idx == 3'(i));
    end

    always_comb begin
        logic legal;
        dec   = '0;
        legal = 1'b1;
        if (is_ext) begin
            dec.valid = 1'b1;
            unique case (sc)
                SC_CTRL: begin
                    unique case (low6)
                        6'o00:   dec.act = CA_HALT;
                        6'o01:   dec.act = CA_IRQ_OFF;
                        6'o02:   dec.act = CA_TRAP_OFF;
                        6'o11:   dec.act = CA_IRQ_ON;
                        6'o12:   dec.act = CA_TRAP_ON;
                        default: legal   = 1'b0;
                    endcase
                end
                SC_PGCH: begin
                    if (!insn[5]) begin
                        dec.ld       = LD_PAGE;
                        dec.page_val = insn[PAGE_W-1:0];
                    end else if (!insn[4]) begin
                        dec.ld       = LD_CHAN;
                        dec.chan_val = insn[CHAN_W-1:0];
                    end else begin
                        legal = 1'b0;
                    end
                end
                SC_ALU: begin
                    dec.rfield = {1'b0, insn[5:4]};
                    dec.fn     = insn[FN_W-1:0];
                end
                SC_BRANCH: begin
                    if (!insn[3] && (insn[2:0] != 3'b000)) legal = 1'b0;
                    else dec.rfield = insn[2:0];
                end
                SC_STACK: begin
                    if (insn[4:3] != 2'b00) legal = 1'b0;
                    else begin
                        dec.rfield = insn[2:0];
                        dec.pop    = insn[5];
                    end
                end
                SC_INCDEC: begin
                    if (insn[5:4] != 2'b00) legal = 1'b0;
                    else begin
                        dec.rfield = insn[2:0];
                        dec.up     = insn[3];
                    end
                end
                SC_CALLZA, SC_CALLZB: begin
                    dec.ptr = insn[PTR_W-1:0];
                end
                default: legal = 1'b0;
            endcase
            if (legal) begin
                dec.sel = sel_hot;
            end else begin
                dec          = '0;
                dec.valid    = 1'b1;
                dec.illegal  = 1'b1;
            end
        end
    end
endmodule

// File: rtl/xd_ctrl_fsm.sv
module xd_ctrl_fsm
    import xd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  dec_s              dec,
    output logic              halted,
    output logic              irq_en,
    output logic              trap_en,
    output logic [PAGE_W-1:0] page_q,
    output logic [CHAN_W-1:0] chan_q
);
    typedef enum logic {ST_RUN, ST_HALT} run_state_e;

    run_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:  if (dec.act == CA_HALT) state_d = ST_HALT;
            ST_HALT: state_d = ST_HALT;
            default: state_d = ST_RUN;
        endcase
    end

    assign halted = (state_q == ST_HALT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_en  <= 1'b0;
            trap_en <= 1'b0;
        end else begin
            unique case (dec.act)
                CA_IRQ_OFF:  irq_en  <= 1'b0;
                CA_IRQ_ON:   irq_en  <= 1'b1;
                CA_TRAP_OFF: trap_en <= 1'b0;
                CA_TRAP_ON:  trap_en <= 1'b1;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            page_q <= '0;
            chan_q <= '0;
        end else begin
            unique case (dec.ld)
                LD_PAGE: page_q <= dec.page_val;
                LD_CHAN: chan_q <= dec.chan_val;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/xd_out_reg.sv
module xd_out_reg
    import xd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  dec_s             dec,
    output logic             dec_valid,
    output logic [NSEL-1:0]  sub_sel,
    output logic [RF_W-1:0]  reg_field,
    output logic [FN_W-1:0]  alu_fn,
    output logic             step_up,
    output logic             is_pop,
    output logic [PTR_W-1:0] zp_ptr,
    output logic             illegal
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dec_valid <= 1'b0;
            sub_sel   <= '0;
            reg_field <= '0;
            alu_fn    <= '0;
            step_up   <= 1'b0;
            is_pop    <= 1'b0;
            zp_ptr    <= '0;
            illegal   <= 1'b0;
        end else begin
            dec_valid <= dec.valid;
            sub_sel   <= dec.sel;
            reg_field <= dec.rfield;
            alu_fn    <= dec.fn;
            step_up   <= dec.up;
            is_pop    <= dec.pop;
            zp_ptr    <= dec.ptr;
            illegal   <= dec.illegal;
        end
    end
endmodule

// File: rtl/xcls_decoder.sv
module xcls_decoder
    import xd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              insn_valid,
    input  logic [INSN_W-1:0] insn,
    output logic              dec_valid,
    output logic [NSEL-1:0]   sub_sel,
    output logic [RF_W-1:0]   reg_field,
    output logic [FN_W-1:0]   alu_fn,
    output logic              step_up,
    output logic              is_pop,
    output logic [PTR_W-1:0]  zp_ptr,
    output logic              illegal,
    output logic              halted,
    output logic              irq_en,
    output logic              trap_en,
    output logic [PAGE_W-1:0] page_q,
    output logic [CHAN_W-1:0] chan_q
);
    dec_s dec;

    xd_classify u_classify (
        .insn_valid (insn_valid),
        .insn       (insn),
        .dec        (dec)
    );

    xd_ctrl_fsm u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .dec     (dec),
        .halted  (halted),
        .irq_en  (irq_en),
        .trap_en (trap_en),
        .page_q  (page_q),
        .chan_q  (chan_q)
    );

    xd_out_reg u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .dec       (dec),
        .dec_valid (dec_valid),
        .sub_sel   (sub_sel),
        .reg_field (reg_field),
        .alu_fn    (alu_fn),
        .step_up   (step_up),
        .is_pop    (is_pop),
        .zp_ptr    (zp_ptr),
        .illegal   (illegal)
    );
endmodule

// File: rtl/xd_checker.sv
module xd_checker
    import xd_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              insn_valid,
    input logic [INSN_W-1:0] insn,
    input logic              dec_valid,
    input logic [NSEL-1:0]   sub_sel,
    input logic              illegal,
    input logic              halted,
    input logic              irq_en,
    input logic              trap_en,
    input logic [PAGE_W-1:0] page_q,
    input logic [CHAN_W-1:0] chan_q
);
    logic seen_edge;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen_edge <= 1'b0;
        else        seen_edge <= 1'b1;
    end

    p_sel_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sub_sel) && (!dec_valid || illegal || $countones(sub_sel) == 1));

    p_illegal_nosel_r10: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (sub_sel == '0) && dec_valid);

    p_illegal_regs_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (illegal && seen_edge) |-> ($stable(page_q) && $stable(chan_q) &&
                                    $stable(irq_en) && $stable(trap_en) && $stable(halted)));

    p_halt_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);

    p_idle_quiet_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_valid |-> (sub_sel == '0) && !illegal);

    p_nonext_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_valid && insn[INSN_W-1:INSN_W-3] != 3'b111) |=> !dec_valid);
endmodule

bind xcls_decoder xd_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .insn_valid (insn_valid),
    .insn       (insn),
    .dec_valid  (dec_valid),
    .sub_sel    (sub_sel),
    .illegal    (illegal),
    .halted     (halted),
    .irq_en     (irq_en),
    .trap_en    (trap_en),
    .page_q     (page_q),
    .chan_q     (chan_q)
);

// File: tb/tb_xcls_decoder.sv
module tb_xcls_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        insn_valid = 1'b0;
    logic [11:0] insn = '0;
    logic        dec_valid, step_up, is_pop, illegal, halted, irq_en, trap_en;
    logic [6:0]  sub_sel, zp_ptr;
    logic [2:0]  reg_field;
    logic [3:0]  alu_fn, chan_q;
    logic [4:0]  page_q;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    xcls_decoder dut (
        .clk(clk), .rst_n(rst_n), .insn_valid(insn_valid), .insn(insn),
        .dec_valid(dec_valid), .sub_sel(sub_sel), .reg_field(reg_field),
        .alu_fn(alu_fn), .step_up(step_up), .is_pop(is_pop), .zp_ptr(zp_ptr),
        .illegal(illegal), .halted(halted), .irq_en(irq_en), .trap_en(trap_en),
        .page_q(page_q), .chan_q(chan_q)
    );

    // reference model state (expected outputs after the latest edge)
    int e_valid, e_sel, e_rf, e_fn, e_up, e_pop, e_ptr, e_ill;
    int e_halt, e_irq, e_trap, e_page, e_chan;

    task automatic model_reset();
        e_valid = 0; e_sel = 0; e_rf = 0; e_fn = 0; e_up = 0; e_pop = 0;
        e_ptr = 0; e_ill = 0; e_halt = 0; e_irq = 0; e_trap = 0; e_page = 0; e_chan = 0;
    endtask

    task automatic model_step(input int v, input int w);
        int sc, lo, ok;
        e_valid = 0; e_sel = 0; e_rf = 0; e_fn = 0; e_up = 0; e_pop = 0; e_ptr = 0; e_ill = 0;
        if (v != 0 && (w / 512) == 7) begin
            sc = (w / 64) % 8;
            lo = w % 64;
            ok = 1;
            e_valid = 1;
            if (sc == 0) begin
                if (lo == 0)       e_halt = 1;
                else if (lo == 1)  e_irq = 0;
                else if (lo == 2)  e_trap = 0;
                else if (lo == 9)  e_irq = 1;
                else if (lo == 10) e_trap = 1;
                else ok = 0;
            end else if (sc == 1) begin
                if (lo < 32)       e_page = lo;
                else if (lo < 48)  e_chan = lo - 32;
                else ok = 0;
            end else if (sc == 2) begin
                e_rf = lo / 16; e_fn = lo % 16;
            end else if (sc == 3) begin
                if ((lo % 16) >= 8 || (lo % 16) == 0) e_rf = lo % 8;
                else ok = 0;
            end else if (sc == 4) begin
                if (((lo / 8) % 4) == 0) begin e_rf = lo % 8; e_pop = lo / 32; end
                else ok = 0;
            end else if (sc == 5) begin
                if (lo < 16) begin e_rf = lo % 8; e_up = lo / 8; end
                else ok = 0;
            end else begin
                e_ptr = w % 128;
            end
            if (ok != 0) e_sel = 1 << ((sc == 7) ? 6 : sc);
            else begin e_rf = 0; e_fn = 0; e_up = 0; e_pop = 0; e_ptr = 0; e_ill = 1; end
        end
    endtask

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) model_reset();
        else model_step(int'(insn_valid), int'(insn));
    end

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // every-cycle comparison at the falling edge
    always @(negedge clk) begin
        if (rst_n) begin
            string rtag;
            rtag = (e_sel == 8) ? "R6" : (e_sel == 16) ? "R7" : (e_sel == 32) ? "R8" : "R5";
            chk("R1",  "dec_valid", int'(dec_valid), e_valid);
            chk(e_valid != 0 ? "R2" : "R13", "sub_sel", int'(sub_sel), e_sel);
            chk(rtag,  "reg_field", int'(reg_field), e_rf);
            chk("R5",  "alu_fn",    int'(alu_fn), e_fn);
            chk("R8",  "step_up",   int'(step_up), e_up);
            chk("R7",  "is_pop",    int'(is_pop), e_pop);
            chk("R9",  "zp_ptr",    int'(zp_ptr), e_ptr);
            chk("R10", "illegal",   int'(illegal), e_ill);
            chk("R12", "halted",    int'(halted), e_halt);
            chk("R3",  "irq_en",    int'(irq_en), e_irq);
            chk("R3",  "trap_en",   int'(trap_en), e_trap);
            chk("R4",  "page_q",    int'(page_q), e_page);
            chk("R4",  "chan_q",    int'(chan_q), e_chan);
        end
    end

    task automatic put(input logic v, input logic [11:0] w);
        @(negedge clk);
        insn_valid = v;
        insn = w;
    endtask

    // watchdog
    initial begin
        #1500000;
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset values seen at the ports
        chk("R11", "reset dec_valid", int'(dec_valid), 0);
        chk("R11", "reset flags", int'({halted, irq_en, trap_en}), 0);
        chk("R11", "reset page/chan", int'({page_q, chan_q}), 0);
        chk("R11", "reset sel", int'(sub_sel), 0);
        rst_n = 1'b1;
        // control codes, defined and undefined neighbours (R3, R10)
        put(1, 12'o7011); put(1, 12'o7012); put(1, 12'o7003); put(1, 12'o7010);
        put(1, 12'o7001); put(1, 12'o7040); put(1, 12'o7002); put(1, 12'o7077);
        // page/channel (R4) including reserved 11
        put(1, 12'o7125); put(1, 12'o7156); put(1, 12'o7163); put(1, 12'o7177);
        // ALU forms (R5)
        put(1, 12'o7203); put(1, 12'o7267);
        // branches (R6): unconditional with bad condition is illegal
        put(1, 12'o7300); put(1, 12'o7305); put(1, 12'o7315); put(1, 12'o7360);
        // stack (R7)
        put(1, 12'o7405); put(1, 12'o7446); put(1, 12'o7413); put(1, 12'o7421);
        // inc/dec (R8)
        put(1, 12'o7502); put(1, 12'o7517); put(1, 12'o7520);
        // page-zero call (R9)
        put(1, 12'o7621); put(1, 12'o7777);
        // non-extension word and idle cycles (R1, R13)
        put(1, 12'o3456); put(0, 12'o7011); put(0, 12'o0000);
        // halt then more control traffic (R12)
        put(1, 12'o7000); put(1, 12'o7011); put(1, 12'o7000); put(1, 12'o7001);
        // random stream biased toward the extension class
        for (int i = 0; i < 4000; i++) begin
            logic [11:0] w;
            w = 12'($urandom);
            if (($urandom % 4) != 0) w[11:9] = 3'b111;
            put(1'($urandom % 8 != 0), w);
        end
        // mid-run reset returns to zero (R11)
        @(negedge clk);
        rst_n = 1'b0;
        insn_valid = 1'b0;
        @(negedge clk);
        chk("R11", "re-reset halted", int'(halted), 0);
        chk("R11", "re-reset page", int'(page_q), 0);
        rst_n = 1'b1;
        put(1, 12'o7011);
        put(0, 12'o0);
        @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule